// File: doc/BRIEF.md
# Power-Good Timeout Generator

This block drives an active-high power-good flag that also serves as the system reset for logic behind a multi-rail supply sequencer. It watches three kinds of qualification: a per-channel "output is up" flag, a global "enable is above its threshold" flag, and a per-channel "input supply is above its undervoltage threshold" flag. A per-channel mask removes unused rails from the output check. Once every qualification holds, a programmable counter makes the flag wait for a set number of clock cycles before it rises, so downstream logic sees a clean power-on reset delay.

A margin input, active low, lets test firmware move supplies outside their normal windows without disturbing the system. While margin is held low the power-good flag and the timeout counter freeze and the qualification inputs are ignored. Short low glitches on the margin input are filtered out, so only a sustained request enters margin mode. All inputs are assumed to be synchronous to `clk`. The analog comparisons and the open-drain output stage sit outside this block.

Top module: `pg_timeout_gen`

## Requirements
- R1: With `rst_n` sampled low on a rising edge, `pg` is 0 after that edge, and it stays 0 until a full timeout has elapsed after reset is released.
- R2: A cycle is qualified when `en_ok` is 1, every bit of `set_ok` is 1, and for every channel i with `chan_en[i]`=1 the bit `out_good[i]` is 1 (bit i of each vector belongs to channel i). With margin not active, `pg` rises right after the T-th consecutive qualified rising edge, where T = `timeout_cfg` when it is non-zero.
- R3: When `timeout_cfg` is 0, T equals `DEFAULT_TICKS` (default 20000 cycles, which is 200 us at 100 MHz).
- R4: A channel with `chan_en[i]`=0 has no effect: its `out_good[i]` neither blocks nor drops `pg`.
- R5: A non-qualified cycle during the timeout restarts the count from zero, so a further T qualified edges are needed.
- R6: With margin not active, `en_ok`=0 or any `set_ok` bit at 0 on a rising edge drives `pg` to 0 after that edge.
- R7: With margin not active, an enabled channel whose `out_good` bit is 0 on a rising edge drives `pg` to 0 after that edge.
- R8: After `margin_n` has been sampled low on `MARGIN_FILT_CYC` consecutive rising edges (default 10, which is 100 ns at 100 MHz), from the next edge on `pg` and the timeout count hold their values whatever the qualification inputs do.
- R9: A low pulse on `margin_n` that covers fewer than `MARGIN_FILT_CYC` rising edges has no effect: monitoring and counting continue during it.
- R10: The first rising edge that samples `margin_n` high ends margin mode; monitoring acts again from the following edge, and a count that was frozen continues from its held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_en | input | N | Per-channel enable mask for the output check |
| out_good | input | N | Per-channel flag: output above its good threshold |
| set_ok | input | N | Per-channel flag: input supply above its undervoltage threshold |
| en_ok | input | 1 | Enable input above its threshold |
| margin_n | input | 1 | Margin request, active low (tie high when unused) |
| timeout_cfg | input | CNT_W | Timeout in cycles; 0 selects DEFAULT_TICKS |
| pg | output | 1 | Power-good / reset release, active high |

## Verification
The bench builds the block with three channels, a 16-bit timeout field, the 20000-cycle default and a 10-cycle margin filter. A programmed timeout of 8 cycles, and of 30 for the freeze test, keeps the assert, restart and drop windows short enough to check edge by edge. Only the default path then has to run through 20000 cycles. The 10-cycle filter makes a 9-edge margin pulse and an 11-edge margin hold both reachable, so rejection and freeze can be checked against each other.

// File: rtl/pgt_pkg.sv
// Package pgt_pkg
// Shared types for the power-good timeout generator.
package pgt_pkg;

    // Power-good state: not qualified, counting the timeout, asserted.
    typedef enum logic [1:0] {
        PGS_LOW  = 2'd0,
        PGS_WAIT = 2'd1,
        PGS_GOOD = 2'd2
    } pg_state_t;

endpackage

// File: rtl/pgt_margin_filter.sv
// Module pgt_margin_filter
// Turns the active-low margin request into a registered freeze flag.
// The request must be sampled low on FILT_CYC consecutive edges before the
// freeze flag rises; one edge that samples it high clears the flag.
// Assumes margin_n is synchronous to clk.
module pgt_margin_filter #(
    parameter int FILT_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic margin_n,
    output logic frozen
);

    localparam int FW = $clog2(FILT_CYC + 1);
    localparam logic [FW-1:0] RUN_MAX = FW'(FILT_CYC);
    localparam logic [FW-1:0] RUN_ARM = FW'(FILT_CYC - 1);

    logic [FW-1:0] run;

    // Count consecutive low samples (saturating) and raise the freeze flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= '0;
            frozen <= 1'b0;
        end else if (margin_n) begin
            run    <= '0;
            frozen <= 1'b0;
        end else begin
            if (run != RUN_MAX) begin
                run <= run + 1'b1;
            end
            frozen <= (run >= RUN_ARM);
        end
    end

endmodule

// File: rtl/pgt_qualify.sv
// Module pgt_qualify
// Combines the supply, enable and per-channel output flags into one
// qualification bit. Channels with a zero mask bit are treated as good.
// Purely combinational.
module pgt_qualify #(
    parameter int N = 3
) (
    input  logic [N-1:0] chan_en,
    input  logic [N-1:0] out_good,
    input  logic [N-1:0] set_ok,
    input  logic         en_ok,
    output logic         qualified
);

    logic [N-1:0] ch_ok;
    logic         supply_ok;
    logic         outputs_ok;

    // One masking term per channel.
    for (genvar i = 0; i < N; i++) begin : g_chan
        assign ch_ok[i] = out_good[i] | ~chan_en[i];
    end

    // Supply side: enable plus every undervoltage flag.
    always_comb begin
        supply_ok  = en_ok & (&set_ok);
        outputs_ok = &ch_ok;
        qualified  = supply_ok & outputs_ok;
    end

endmodule

// File: rtl/pgt_timer.sv
// Module pgt_timer
// Holds the power-good state and the timeout counter. While qualified it
// counts edges and asserts after the limit; any non-qualified edge clears
// both. While freeze is high all state is held.
// Assumes DEFAULT_TICKS fits in CNT_W bits and is non-zero.
module pgt_timer
    import pgt_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int DEFAULT_TICKS = 20000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze,
    input  logic             qualified,
    input  logic [CNT_W-1:0] timeout_cfg,
    output logic             pg,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] DEF_LIM = CNT_W'(DEFAULT_TICKS);

    pg_state_t        state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [CNT_W-1:0] limit;
    logic [CNT_W:0]   cnt_inc;
    logic             reached;

    // Resolve the limit and test whether this edge completes the timeout.
    always_comb begin
        limit   = (timeout_cfg == '0) ? DEF_LIM : timeout_cfg;
        cnt_inc = {1'b0, cnt} + (CNT_W+1)'(1);
        reached = (cnt_inc >= {1'b0, limit});
    end

    // Next-state rules: freeze holds, loss of qualification clears.
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (!freeze) begin
            if (!qualified) begin
                state_nx = PGS_LOW;
                cnt_nx   = '0;
            end else if (state != PGS_GOOD) begin
                if (reached) begin
                    state_nx = PGS_GOOD;
                    cnt_nx   = '0;
                end else begin
                    state_nx = PGS_WAIT;
                    cnt_nx   = cnt_inc[CNT_W-1:0];
                end
            end
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PGS_LOW;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    assign pg    = (state == PGS_GOOD);
    assign cnt_o = cnt;

endmodule

// File: rtl/pg_timeout_gen.sv
// Module pg_timeout_gen
// Top level of the power-good timeout generator: qualification logic,
// margin glitch filter and timeout state machine.
// Assumes all inputs are synchronous to clk; margin_n is tied high by the
// integrator when no margin control is present.
module pg_timeout_gen #(
    parameter int N               = 3,
    parameter int CNT_W           = 16,
    parameter int DEFAULT_TICKS   = 20000,
    parameter int MARGIN_FILT_CYC = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     chan_en,
    input  logic [N-1:0]     out_good,
    input  logic [N-1:0]     set_ok,
    input  logic             en_ok,
    input  logic             margin_n,
    input  logic [CNT_W-1:0] timeout_cfg,
    output logic             pg
);

    logic             qualified;
    logic             margin_frz;
    logic [CNT_W-1:0] tmr_cnt;

    pgt_qualify #(.N(N)) u_qual (
        .chan_en   (chan_en),
        .out_good  (out_good),
        .set_ok    (set_ok),
        .en_ok     (en_ok),
        .qualified (qualified)
    );

    pgt_margin_filter #(.FILT_CYC(MARGIN_FILT_CYC)) u_margin (
        .clk      (clk),
        .rst_n    (rst_n),
        .margin_n (margin_n),
        .frozen   (margin_frz)
    );

    pgt_timer #(.CNT_W(CNT_W), .DEFAULT_TICKS(DEFAULT_TICKS)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .freeze      (margin_frz),
        .qualified   (qualified),
        .timeout_cfg (timeout_cfg),
        .pg          (pg),
        .cnt_o       (tmr_cnt)
    );

endmodule

// File: rtl/pg_timeout_gen_chk.sv
// Module pg_timeout_gen_chk
// Property checker for pg_timeout_gen, attached with bind below.
// Qualification is rebuilt here from the ports; freeze flag and count are
// taken from the design.
module pg_timeout_gen_chk #(
    parameter int N     = 3,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     chan_en,
    input logic [N-1:0]     out_good,
    input logic [N-1:0]     set_ok,
    input logic             en_ok,
    input logic             margin_n,
    input logic             pg,
    input logic             margin_frz,
    input logic [CNT_W-1:0] tmr_cnt
);

    logic supply_up;
    logic outs_up;
    logic all_up;

    // Port-level view of the qualification terms.
    always_comb begin
        supply_up = en_ok && (set_ok == {N{1'b1}});
        outs_up   = ((out_good | ~chan_en) == {N{1'b1}});
        all_up    = supply_up && outs_up;
    end

    // R1: first cycle after reset release shows power-good low.
    p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !pg);

    // R2: a rise of power-good follows a qualified, unfrozen edge.
    p_rise_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg) |-> $past(all_up && !margin_frz));

    // R4: a masked channel cannot pull down an asserted flag.
    p_masked_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pg && all_up && !margin_frz) |=> pg);

    // R5: a non-qualified edge clears the count.
    p_count_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!margin_frz && !all_up) |=> (tmr_cnt == '0));

    // R6: supply or enable loss drops power-good.
    p_supply_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!margin_frz && !supply_up) |=> !pg);

    // R7: an enabled output losing good drops power-good.
    p_output_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!margin_frz && |(chan_en & ~out_good)) |=> !pg);

    // R8: frozen state holds flag and count.
    p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        margin_frz |=> ($stable(pg) && $stable(tmr_cnt)));

    // R9: freeze only starts from a low margin request.
    p_filter_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(margin_frz) |-> $past(!margin_n));

    // R10: a high margin sample ends freeze on the next edge.
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        margin_n |=> !margin_frz);

endmodule

bind pg_timeout_gen pg_timeout_gen_chk #(.N(N), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_en    (chan_en),
    .out_good   (out_good),
    .set_ok     (set_ok),
    .en_ok      (en_ok),
    .margin_n   (margin_n),
    .pg         (pg),
    .margin_frz (margin_frz),
    .tmr_cnt    (tmr_cnt)
);

// File: tb/test_pg_timeout_gen.sv
// Bench for pg_timeout_gen: behavioural reference model compared on every
// clock, plus directed checks at the edges the requirements name.
module test_pg_timeout_gen;

    localparam int N    = 3;
    localparam int CW   = 16;
    localparam int DEF  = 20000;
    localparam int FILT = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  chan_en, out_good, set_ok;
    logic          en_ok, margin_n;
    logic [CW-1:0] tcfg;
    logic          pg;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // Reference model state.
    bit m_act, m_good, fz, q;
    int m_run, m_cnt, lim;

    always #5 clk = ~clk;

    pg_timeout_gen #(.N(N), .CNT_W(CW), .DEFAULT_TICKS(DEF),
                     .MARGIN_FILT_CYC(FILT)) i_pg_timeout_gen (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .out_good(out_good),
        .set_ok(set_ok), .en_ok(en_ok), .margin_n(margin_n),
        .timeout_cfg(tcfg), .pg(pg)
    );

    // Reference model, advanced on each rising edge from the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_good = 0; m_run = 0; m_cnt = 0;
        end else begin
            fz = m_act;
            if (!margin_n) begin
                if (m_run < FILT) m_run++;
                m_act = (m_run >= FILT);
            end else begin
                m_run = 0;
                m_act = 0;
            end
            if (!fz) begin
                q   = en_ok && (set_ok == '1) && ((out_good | ~chan_en) == '1);
                lim = (tcfg == 0) ? DEF : int'(tcfg);
                if (!q) begin
                    m_good = 0;
                    m_cnt  = 0;
                end else if (!m_good) begin
                    m_cnt++;
                    if (m_cnt >= lim) begin
                        m_good = 1;
                        m_cnt  = 0;
                    end
                end
            end
        end
    end

    task automatic chk(input string t, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pg=%0b expected %0b at %0t", t, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Every-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) chk({tag, " model"}, pg, m_good);
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL %s: watchdog expired, finished=0 expected 1", tag);
            finish_run();
        end
    end

    initial begin
        chan_en = '1; out_good = '0; set_ok = '1;
        en_ok = 1'b0; margin_n = 1'b1; tcfg = CW'(8);
        cyc(3);
        tag = "R1"; chk("R1 in reset", pg, 1'b0);
        rst_n = 1'b1;
        cyc(2); chk("R1 after release", pg, 1'b0);

        // R2: qualified run of 8 edges.
        tag = "R2";
        en_ok = 1'b1; out_good = '1;
        cyc(7); chk("R2 edge 7", pg, 1'b0);
        cyc(1); chk("R2 edge 8", pg, 1'b1);

        // R6: enable and undervoltage flags.
        tag = "R6";
        en_ok = 1'b0; cyc(1); chk("R6 en_ok low", pg, 1'b0);
        en_ok = 1'b1; cyc(8); chk("R6 requalify", pg, 1'b1);
        set_ok[1] = 1'b0; cyc(1); chk("R6 set_ok[1] low", pg, 1'b0);
        set_ok = '1; cyc(8); chk("R6 requalify set", pg, 1'b1);

        // R7: enabled output drops.
        tag = "R7";
        out_good[0] = 1'b0; cyc(1); chk("R7 out_good[0] low", pg, 1'b0);
        out_good = '1;

        // R5: interruption mid-count restarts it.
        tag = "R5";
        cyc(5);
        out_good[2] = 1'b0; cyc(1);
        out_good[2] = 1'b1;
        cyc(7); chk("R5 restarted edge 7", pg, 1'b0);
        cyc(1); chk("R5 restarted edge 8", pg, 1'b1);

        // R4: masked channel ignored.
        tag = "R4";
        chan_en = 3'b011; out_good = 3'b011;
        cyc(1); chk("R4 masked drop ignored", pg, 1'b1);
        en_ok = 1'b0; cyc(1); en_ok = 1'b1;
        cyc(8); chk("R4 asserts with masked channel low", pg, 1'b1);
        chan_en = '1; out_good = '1;

        // R8: sustained margin freezes an asserted flag.
        tag = "R8";
        margin_n = 1'b0; cyc(FILT + 1);
        en_ok = 1'b0; out_good = '0;
        cyc(5); chk("R8 frozen high", pg, 1'b1);

        // R10: release acts one edge later.
        tag = "R10";
        margin_n = 1'b1;
        cyc(1); chk("R10 release edge still frozen", pg, 1'b1);
        cyc(1); chk("R10 monitoring resumed", pg, 1'b0);

        // R10 with R8: count frozen mid-way, then continues.
        tcfg = CW'(30);
        en_ok = 1'b1; out_good = '1; margin_n = 1'b0;
        cyc(FILT + 40); chk("R8 count frozen", pg, 1'b0);
        margin_n = 1'b1;
        cyc(20); chk("R10 count resumed, edge 29", pg, 1'b0);
        cyc(1);  chk("R10 count resumed, edge 30", pg, 1'b1);

        // R9: short margin pulse rejected.
        tag = "R9";
        tcfg = CW'(8);
        margin_n = 1'b0; en_ok = 1'b0;
        cyc(1); chk("R9 drop seen during short pulse", pg, 1'b0);
        en_ok = 1'b1;
        cyc(8); chk("R9 counting during short pulse", pg, 1'b1);
        margin_n = 1'b1;

        // R3: zero selects the default timeout.
        tag = "R3";
        tcfg = '0; en_ok = 1'b0; cyc(1); en_ok = 1'b1;
        cyc(DEF - 1); chk("R3 default edge 19999", pg, 1'b0);
        cyc(1);       chk("R3 default edge 20000", pg, 1'b1);

        cyc(2);
        finish_run();
    end

endmodule